// File: doc/BRIEF.md
# Two-Half Long Branch Sequencer

This unit carries out a long branch-with-link that reaches the core as two consecutive 16-bit halves. The leading half adds a sign-extended high offset to the current PC. It parks that partial target in the link register. The trailing half adds a low offset to the partial target, jumps there, and leaves a return address in the link register. In newer-architecture mode an exchange form of the trailing half also exists. That form forces the target to a word boundary and tells the core to leave compressed-instruction mode.

A fetch stage presents one halfword per cycle on `half_valid`, with its address and the architectural link value. The sequencer keeps its own copy of the partial target while it waits for the trailing half. A trailing half that arrives without a leading half is still executed, using whatever `link_in` holds. Every result is registered and appears as a one-cycle strobe on the cycle after the half is presented.

Top module: `long_branch_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, every strobe (`pc_we`, `lr_we`, `mode_clr`, `flush`, `undef`) is low and the sequencer is idle.
- R2: A half with bits 15:11 = 11110 gives, one cycle later, `lr_we`=1 and `lr_next` = `half_pc` + 4 + (bits 10:0 sign-extended from bit 10, shifted left 12). `pc_we` and `flush` stay low. The sequencer then awaits a trailing half.
- R3: A half with bits 15:11 = 11111 gives, one cycle later, `pc_we`=1 with `pc_next` = base + (bits 10:0 shifted left 1). It also gives `lr_we`=1 with `lr_next` = (`half_pc` + 2) with bit 0 set, `flush`=1 and `mode_clr`=0.
- R4: A half with bits 15:11 = 11101, bit 0 = 0 and `v5_mode`=1 acts as R3, except that `pc_next` has bits 1:0 cleared and `mode_clr`=1.
- R5: A half with bits 15:11 = 11101 and bit 0 = 1 raises only `undef`, with no PC or link write and no flush.
- R6: A half with bits 15:11 = 11101 while `v5_mode`=0 raises only `undef`.
- R7: When a trailing half is executed from idle, the base is `link_in`. When it follows a leading half, the base is the partial target held inside the unit, and `link_in` has no effect.
- R8: In the awaiting state, a half that is neither a trailing nor a leading form produces no strobe and returns the sequencer to idle.
- R9: A leading half that arrives while the sequencer awaits replaces the held partial target with the new one.
- R10: Cycles without `half_valid` produce no strobe, and they keep the awaiting state and its held partial target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_valid | input | 1 | A halfword is presented this cycle |
| half_instr | input | 16 | Instruction halfword |
| half_pc | input | AW | Address of the presented halfword |
| link_in | input | AW | Current architectural link register |
| v5_mode | input | 1 | Newer-architecture mode enable |
| pc_we | output | 1 | Write strobe for the PC |
| pc_next | output | AW | New PC value |
| lr_we | output | 1 | Write strobe for the link register |
| lr_next | output | AW | New link register value |
| mode_clr | output | 1 | Clear the compressed-mode flag |
| flush | output | 1 | Pipeline flush on a taken jump |
| undef | output | 1 | Undefined-instruction strobe |

## Verification
If the state register is wrong, the trailing half picks the wrong base. The jump target then differs from the expected value on the very next cycle. The check that drives a junk `link_in` during a paired trailing half, and a chosen `link_in` during a lone one, exposes this at once. If the held partial target is lost, for example across idle cycles, `pc_next` is wrong on the cycle after the trailing half. Decode errors show up in the same cycle as a wrong combination of `undef`, `mode_clr` and the write strobes.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_AWAIT = 1'b1
    } seq_state_e;

    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_FIRST   = 3'd1,
        K_SECOND  = 3'd2,
        K_XSECOND = 3'd3,
        K_UNDEF   = 3'd4
    } half_kind_e;

    localparam logic [4:0] OP_FIRST   = 5'b11110;
    localparam logic [4:0] OP_SECOND  = 5'b11111;
    localparam logic [4:0] OP_XSECOND = 5'b11101;
endpackage

// File: rtl/lbs_decode.sv
module lbs_decode
    import lbs_pkg::*;
(
    input  logic [15:0] half,
    input  logic        newer_arch,
    output half_kind_e  kind
);
    logic [4:0] op;
    assign op = half[15:11];

    always_comb begin
        kind = K_NONE;
        if (op == OP_FIRST) begin
            kind = K_FIRST;
        end else if (op == OP_SECOND) begin
            kind = K_SECOND;
        end else if (op == OP_XSECOND) begin
            kind = (newer_arch && !half[0]) ? K_XSECOND : K_UNDEF;
        end
    end
endmodule

// File: rtl/lbs_addr.sv
module lbs_addr #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] half_pc,
    input  logic [10:0]   off,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] first_link,
    output logic [AW-1:0] jump_sum,
    output logic [AW-1:0] ret_link
);
    localparam int OFFW   = 11;
    localparam int HI_SH  = 12;
    localparam int HI_EXT = AW - OFFW - HI_SH;
    localparam int LO_EXT = AW - OFFW - 1;

    logic [AW-1:0] hi_off;
    logic [AW-1:0] lo_off;
    logic [AW-1:0] after_half;

    assign hi_off     = {{HI_EXT{off[OFFW-1]}}, off, {HI_SH{1'b0}}};
    assign lo_off     = {{LO_EXT{1'b0}}, off, 1'b0};
    assign first_link = half_pc + AW'(4) + hi_off;
    assign jump_sum   = base + lo_off;
    assign after_half = half_pc + AW'(2);
    assign ret_link   = {after_half[AW-1:1], 1'b1};
endmodule

// File: rtl/long_branch_seq.sv
module long_branch_seq
    import lbs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          half_valid,
    input  logic [15:0]   half_instr,
    input  logic [AW-1:0] half_pc,
    input  logic [AW-1:0] link_in,
    input  logic          v5_mode,
    output logic          pc_we,
    output logic [AW-1:0] pc_next,
    output logic          lr_we,
    output logic [AW-1:0] lr_next,
    output logic          mode_clr,
    output logic          flush,
    output logic          undef
);
    typedef struct packed {
        seq_state_e    state;
        logic [AW-1:0] hold;
        logic          pc_we;
        logic [AW-1:0] pc_next;
        logic          lr_we;
        logic [AW-1:0] lr_next;
        logic          mode_clr;
        logic          flush;
        logic          undef;
    } regs_t;

    regs_t         r_d, r_q;
    half_kind_e    kind_d;
    logic [AW-1:0] base_d;
    logic [AW-1:0] first_link_d;
    logic [AW-1:0] jump_sum_d;
    logic [AW-1:0] ret_link_d;

    assign base_d = (r_q.state == ST_AWAIT) ? r_q.hold : link_in;

    lbs_decode u_dec (
        .half       (half_instr),
        .newer_arch (v5_mode),
        .kind       (kind_d)
    );

    lbs_addr #(.AW(AW)) u_addr (
        .half_pc    (half_pc),
        .off        (half_instr[10:0]),
        .base       (base_d),
        .first_link (first_link_d),
        .jump_sum   (jump_sum_d),
        .ret_link   (ret_link_d)
    );

    always_comb begin
        r_d          = r_q;
        r_d.pc_we    = 1'b0;
        r_d.lr_we    = 1'b0;
        r_d.mode_clr = 1'b0;
        r_d.flush    = 1'b0;
        r_d.undef    = 1'b0;
        if (half_valid) begin
            r_d.state = ST_IDLE;
            case (kind_d)
                K_FIRST: begin
                    r_d.state   = ST_AWAIT;
                    r_d.hold    = first_link_d;
                    r_d.lr_we   = 1'b1;
                    r_d.lr_next = first_link_d;
                end
                K_SECOND: begin
                    r_d.pc_we   = 1'b1;
                    r_d.pc_next = jump_sum_d;
                    r_d.lr_we   = 1'b1;
                    r_d.lr_next = ret_link_d;
                    r_d.flush   = 1'b1;
                end
                K_XSECOND: begin
                    r_d.pc_we    = 1'b1;
                    r_d.pc_next  = {jump_sum_d[AW-1:2], 2'b00};
                    r_d.lr_we    = 1'b1;
                    r_d.lr_next  = ret_link_d;
                    r_d.flush    = 1'b1;
                    r_d.mode_clr = 1'b1;
                end
                K_UNDEF: begin
                    r_d.undef = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.hold     <= '0;
            r_q.pc_we    <= 1'b0;
            r_q.pc_next  <= '0;
            r_q.lr_we    <= 1'b0;
            r_q.lr_next  <= '0;
            r_q.mode_clr <= 1'b0;
            r_q.flush    <= 1'b0;
            r_q.undef    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pc_we    = r_q.pc_we;
    assign pc_next  = r_q.pc_next;
    assign lr_we    = r_q.lr_we;
    assign lr_next  = r_q.lr_next;
    assign mode_clr = r_q.mode_clr;
    assign flush    = r_q.flush;
    assign undef    = r_q.undef;
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          half_valid,
    input logic [15:0]   half_instr,
    input logic          v5_mode,
    input logic          pc_we,
    input logic [AW-1:0] pc_next,
    input logic          lr_we,
    input logic [AW-1:0] lr_next,
    input logic          mode_clr,
    input logic          flush,
    input logic          undef
);
    assert_first_link_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(half_valid) && $past(half_instr[15:11]) == 5'b11110)
        |-> (lr_we && !pc_we && !flush && !undef));

    assert_jump_return_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> (lr_we && lr_next[0] && flush));

    assert_exchange_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_clr |-> (pc_we && pc_next[1:0] == 2'b00));

    assert_odd_exchange_undef_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(half_valid) && $past(half_instr[15:11]) == 5'b11101 && $past(half_instr[0]))
        |-> (undef && !pc_we && !lr_we && !flush));

    assert_old_mode_undef_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(half_valid) && $past(half_instr[15:11]) == 5'b11101 && !$past(v5_mode))
        |-> (undef && !pc_we && !lr_we && !mode_clr));

    assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(half_valid) |-> !(pc_we || lr_we || mode_clr || flush || undef));
endmodule

bind long_branch_seq lbs_checker #(.AW(AW)) u_lbs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_valid (half_valid),
    .half_instr (half_instr),
    .v5_mode    (v5_mode),
    .pc_we      (pc_we),
    .pc_next    (pc_next),
    .lr_we      (lr_we),
    .lr_next    (lr_next),
    .mode_clr   (mode_clr),
    .flush      (flush),
    .undef      (undef)
);

// File: tb/test_long_branch_seq.sv
module test_long_branch_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        half_valid = 1'b0;
    logic [15:0] half_instr = '0;
    logic [31:0] half_pc = '0;
    logic [31:0] link_in = '0;
    logic        v5_mode = 1'b0;
    logic        pc_we, lr_we, mode_clr, flush, undef;
    logic [31:0] pc_next, lr_next;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    long_branch_seq #(.AW(32)) i_long_branch_seq (
        .clk(clk), .rst_n(rst_n), .half_valid(half_valid), .half_instr(half_instr),
        .half_pc(half_pc), .link_in(link_in), .v5_mode(v5_mode),
        .pc_we(pc_we), .pc_next(pc_next), .lr_we(lr_we), .lr_next(lr_next),
        .mode_clr(mode_clr), .flush(flush), .undef(undef)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [15:0] h, input logic [31:0] pc,
                        input logic [31:0] lr, input logic v5);
        @(negedge clk);
        half_valid = v; half_instr = h; half_pc = pc; link_in = lr; v5_mode = v5;
        @(posedge clk);
        #2;
    endtask

    function automatic logic [4:0] strobes();
        return {pc_we, lr_we, mode_clr, flush, undef};
    endfunction

    function automatic logic [31:0] hi_link(input logic [31:0] pc, input logic [10:0] off);
        logic [31:0] ext;
        ext = {{21{off[10]}}, off};
        return pc + 32'd4 + (ext << 12);
    endfunction

    task automatic do_first(input string tag, input logic [10:0] off, input logic [31:0] pc,
                            output logic [31:0] held);
        held = hi_link(pc, off);
        step(1'b1, {5'b11110, off}, pc, 32'hDEAD_BEEF, 1'b1);
        chk({tag, " first strobes"}, 32'(strobes()), 32'b01000);
        chk({tag, " first link"}, lr_next, held);
    endtask

    task automatic do_second(input string tag, input int kind, input logic [10:0] off,
                             input logic [31:0] pc, input logic [31:0] lr,
                             input logic [31:0] base, input logic v5);
        logic [15:0] h;
        logic [31:0] tgt, ret;
        h = (kind == 0) ? {5'b11111, off} : {5'b11101, off};
        tgt = base + {20'd0, off, 1'b0};
        ret = (pc + 32'd2) | 32'd1;
        step(1'b1, h, pc, lr, v5);
        if (kind == 0) begin
            chk({tag, " plain strobes"}, 32'(strobes()), 32'b11010);
            chk({tag, " plain target"}, pc_next, tgt);
            chk({tag, " plain return"}, lr_next, ret);
        end else if (v5 && !off[0]) begin
            chk({tag, " exch strobes"}, 32'(strobes()), 32'b11110);
            chk({tag, " exch target"}, pc_next, tgt & 32'hFFFF_FFFC);
            chk({tag, " exch return"}, lr_next, ret);
        end else begin
            chk({tag, " undef strobes"}, 32'(strobes()), 32'b00001);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 strobes in reset", 32'(strobes()), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R1 strobes after reset", 32'(strobes()), 32'd0);
        // R1: idle after reset, so a lone trailing half uses link_in (R7)
        do_second("R1 R7 lone after reset", 0, 11'h123, 32'h0000_4000, 32'h1000_0000,
                  32'h1000_0000, 1'b1);

        // Sweep: R2 leading half, R3/R4/R5/R6 trailing forms, R7 held base, R10 gaps
        for (int i = 0; i < 96; i++) begin
            logic [10:0] o1, o2;
            logic [31:0] pc1;
            int k;
            o1 = (i == 0) ? 11'h000 : (i == 1) ? 11'h400 : (i == 2) ? 11'h7FF : 11'((i * 331) & 2047);
            o2 = 11'((i * 173 + 5) & 2047);
            pc1 = 32'h0001_0000 + 32'(i * 68);
            k = i % 4;
            do_first("R2", o1, pc1, held);
            if (i % 3 == 0) begin
                step(1'b0, 16'hF800, pc1, 32'h5555_5555, 1'b1);
                chk("R10 gap quiet", 32'(strobes()), 32'd0);
            end
            case (k)
                0: do_second("R3 R7", 0, o2, pc1 + 32'd2, 32'hA5A5_A5A5, held, 1'b1);
                1: do_second("R4 R7", 1, o2 & 11'h7FE, pc1 + 32'd2, 32'hA5A5_A5A5, held, 1'b1);
                2: do_second("R5", 1, o2 | 11'h001, pc1 + 32'd2, 32'hA5A5_A5A5, held, 1'b1);
                default: do_second("R6", 1, o2 & 11'h7FE, pc1 + 32'd2, 32'hA5A5_A5A5, held, 1'b0);
            endcase
        end

        // R5/R6 leave the unit idle: the next trailing half uses link_in
        do_second("R7 lone after undef", 1, 11'h0A4, 32'h0002_0002, 32'h3000_0001,
                  32'h3000_0001, 1'b1);

        // R8: a non-branch half in the awaiting state returns to idle
        do_first("R8", 11'h055, 32'h0003_0000, held);
        step(1'b1, 16'h2345, 32'h0003_0002, 32'h0, 1'b1);
        chk("R8 other half quiet", 32'(strobes()), 32'd0);
        do_second("R8 base is link_in", 0, 11'h010, 32'h0003_0004, 32'h7000_0000,
                  32'h7000_0000, 1'b1);

        // R9: a second leading half replaces the held value
        do_first("R9 a", 11'h001, 32'h0004_0000, held);
        do_first("R9 b", 11'h7F0, 32'h0004_0002, held);
        do_second("R9 uses newer", 0, 11'h3FF, 32'h0004_0004, 32'h0, held, 1'b1);

        // R10: several idle cycles keep the held value
        do_first("R10", 11'h200, 32'h0005_0000, held);
        for (int j = 0; j < 4; j++) begin
            step(1'b0, 16'hFFFF, 32'h0, 32'h0, 1'b1);
            chk("R10 idle quiet", 32'(strobes()), 32'd0);
        end
        do_second("R10 held survives", 1, 11'h012, 32'h0005_0002, 32'h0BAD_0000, held, 1'b1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule